// File: doc/BRIEF.md
# Call/Return Program Sequencer with Register-File Stack

This block owns the program counter and the return-address stack of a small 4-bit controller. Each cycle it takes decoded strobes from the instruction decoder (sequential step, jump, call, return, all-clear) and works out the next 10-bit program address. Jumps can be unconditional or can test a carry flag or a status flag. The target comes either from an immediate field or from a pair of 5-bit registers.

There is no dedicated stack memory. Return addresses live in the top four register pairs of the 32 x 5-bit register file, which is modelled here as a plain array with one general write port. A 2-bit stack pointer selects the slot. When a call would push past the deepest slot, or a return finds the stack empty, the block does not wrap. It forces an internal reset of the program counter and stack pointer and pulses a fault output for one cycle.

Top module: `pc_stack_seq`

## Requirements
- R1: On `rst_n` low, or in the cycle after `clr_all` is sampled high, `pc` is 000h, `sp` is 00b and `fault_rst` is 0.
- R2: A step strobe (`adv_req`) with no higher-priority strobe adds `step_len` (0 to 3) to `pc`, modulo 1024. With no strobe at all, `pc` holds.
- R3: A taken jump loads `pc` with its target. The target is `imm_addr` when `jmp_use_reg` is 0.
- R4: The `jmp_cond` encoding is as follows: 0 means always, 1 means carry set, 2 means carry clear, 3 means status flag set, 4 means status flag clear, and 5 to 7 mean never taken. A jump that is not taken advances `pc` by `step_len`.
- R5: With `jmp_use_reg` set, the target is register pair `jmp_reg_sel`. Its upper 5 bits come from the high half and its lower 5 bits from the low half. The write port addresses the high half when `rf_waddr[4]` is 1 and the low half when it is 0; `rf_waddr[3:0]` is the pair index.
- R6: A register-sourced jump that names pair 0 is ignored. `pc` advances by `step_len` whatever the condition.
- R7: A call with `sp` below 11b writes `pc+1` into stack slot `sp` and loads `pc` with `imm_addr`, then `sp` increments. Slot 0 is pair F, slot 1 is pair E, slot 2 is pair D and slot 3 is pair C.
- R8: A return with `sp` above 00b decrements `sp` and loads `pc` with the value in slot `sp-1` plus 2.
- R9: A call with `sp` = 11b is an overflow. `pc` and `sp` go to zero, `fault_rst` is high for the next cycle, and no register is written.
- R10: A return with `sp` = 00b is an underflow. `pc` and `sp` go to zero and `fault_rst` is high for the next cycle.
- R11: When several strobes are asserted together, the priority is `clr_all`, then call, then return, then jump, then step.
- R12: Stack slots are ordinary register pairs. A register-sourced jump can read a saved return address, and a general write to a slot changes where the matching return goes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all | input | 1 | Synchronous all-clear strobe |
| adv_req | input | 1 | Sequential step strobe |
| step_len | input | 2 | Step / fall-through increment |
| jmp_req | input | 1 | Jump strobe |
| jmp_cond | input | 3 | Jump condition code |
| jmp_use_reg | input | 1 | Take the jump target from a register pair |
| jmp_reg_sel | input | 4 | Register pair index for the jump target |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe |
| imm_addr | input | 10 | Immediate jump or call target |
| carry_flag | input | 1 | Carry flag from the datapath |
| stat_flag | input | 1 | Status flag from the datapath |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 5 | Register file write address (bit 4 selects the high half) |
| rf_wdata | input | 5 | Register file write data |
| pc | output | 10 | Program counter |
| sp | output | 2 | Stack pointer |
| fault_rst | output | 1 | One-cycle pulse after a stack overflow or underflow |

## Verification
Every result is registered. A strobe sampled at one rising edge shows up on `pc`, `sp` and `fault_rst` right after that edge, and nothing is due later than that. A register-file write becomes visible to a jump or return issued on the following edge. The bench drives inputs on the falling edge and reads outputs on the next falling edge, one full cycle after the edge that consumed the strobe. For stack faults it also checks that `fault_rst` has dropped one cycle later.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CLR,
    ACT_CALL,
    ACT_RET,
    ACT_JMP,
    ACT_STEP
  } act_e;

  localparam logic [2:0] COND_ALWAYS = 3'd0;
  localparam logic [2:0] COND_CY     = 3'd1;
  localparam logic [2:0] COND_NCY    = 3'd2;
  localparam logic [2:0] COND_FL     = 3'd3;
  localparam logic [2:0] COND_NFL    = 3'd4;

  // Condition evaluation; unknown codes never take the jump.
  function automatic logic cond_ok(input logic [2:0] code, input logic cy, input logic fl);
    case (code)
      COND_ALWAYS: return 1'b1;
      COND_CY:     return cy;
      COND_NCY:    return !cy;
      COND_FL:     return fl;
      COND_NFL:    return !fl;
      default:     return 1'b0;
    endcase
  endfunction

  // Strobe priority: clear, call, return, jump, step.
  function automatic act_e pick_act(input logic clr, input logic call, input logic ret,
                                    input logic jmp, input logic adv);
    if (clr)       return ACT_CLR;
    else if (call) return ACT_CALL;
    else if (ret)  return ACT_RET;
    else if (jmp)  return ACT_JMP;
    else if (adv)  return ACT_STEP;
    else           return ACT_NONE;
  endfunction

endpackage

// File: rtl/pcseq_sp_ctrl.sv
module pcseq_sp_ctrl
  import pcseq_pkg::*;
#(
  parameter int SP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  act_e            act,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] push_slot,
  output logic [SP_W-1:0] pop_slot,
  output logic            push_ev,
  output logic            pop_ev,
  output logic            ovf_ev,
  output logic            unf_ev,
  output logic            fault_q
);
  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};
  localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

  assign ovf_ev    = (act == ACT_CALL) && (sp_q == SP_TOP);
  assign unf_ev    = (act == ACT_RET)  && (sp_q == '0);
  assign push_ev   = (act == ACT_CALL) && !ovf_ev;
  assign pop_ev    = (act == ACT_RET)  && !unf_ev;
  assign push_slot = sp_q;
  assign pop_slot  = sp_q - SP_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= ovf_ev || unf_ev;
      if (act == ACT_CLR || ovf_ev || unf_ev) sp_q <= '0;
      else if (push_ev)                       sp_q <= sp_q + SP_ONE;
      else if (pop_ev)                        sp_q <= sp_q - SP_ONE;
    end
  end
endmodule

// File: rtl/pcseq_pair_rf.sv
module pcseq_pair_rf #(
  parameter int HALF_W = 5,
  parameter int NREG   = 16,
  parameter int SP_W   = 2,
  localparam int IDX_W = $clog2(NREG),
  localparam int PAIR_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W:0]    wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              push_en,
  input  logic [SP_W-1:0]   push_slot,
  input  logic [PAIR_W-1:0] push_val,
  input  logic [SP_W-1:0]   pop_slot,
  output logic [PAIR_W-1:0] pop_val,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [PAIR_W-1:0] rd_val
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  logic [HALF_W-1:0] lo_mem [NREG];
  logic [HALF_W-1:0] hi_mem [NREG];

  // Stack slot n lives in pair (NREG-1-n): slots grow downward.
  function automatic logic [IDX_W-1:0] slot_idx(input logic [SP_W-1:0] slot);
    return TOP_IDX - IDX_W'(slot);
  endfunction

  logic [IDX_W-1:0] push_idx, pop_idx;
  assign push_idx = slot_idx(push_slot);
  assign pop_idx  = slot_idx(pop_slot);

  always_ff @(posedge clk) begin
    if (push_en) begin
      hi_mem[push_idx] <= push_val[PAIR_W-1:HALF_W];
      lo_mem[push_idx] <= push_val[HALF_W-1:0];
    end else if (wr_en) begin
      if (wr_addr[IDX_W]) hi_mem[wr_addr[IDX_W-1:0]] <= wr_data;
      else                lo_mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  assign pop_val = {hi_mem[pop_idx], lo_mem[pop_idx]};
  assign rd_val  = {hi_mem[rd_sel], lo_mem[rd_sel]};
endmodule

// File: rtl/pcseq_pc_path.sv
module pcseq_pc_path
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int LEN_W   = 2,
  parameter int IDX_W   = 4,
  parameter int CALL_ADJ = 1,
  parameter int RET_ADJ  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic             fault_ev,
  input  logic [LEN_W-1:0] step_len,
  input  logic [2:0]       jmp_cond,
  input  logic             jmp_use_reg,
  input  logic [IDX_W-1:0] jmp_reg_sel,
  input  logic [PC_W-1:0]  imm_addr,
  input  logic             carry_flag,
  input  logic             stat_flag,
  input  logic [PC_W-1:0]  reg_target,
  input  logic [PC_W-1:0]  pop_val,
  output logic [PC_W-1:0]  push_val,
  output logic             jump_taken,
  output logic [PC_W-1:0]  pc_q
);
  function automatic logic [PC_W-1:0] pc_add(input logic [PC_W-1:0] base, input int unsigned n);
    return base + PC_W'(n);
  endfunction

  logic             reg_illegal;
  logic [PC_W-1:0]  jmp_target, fall_pc, pc_d;

  assign reg_illegal = jmp_use_reg && (jmp_reg_sel == '0);
  assign jump_taken  = (act == ACT_JMP) && !reg_illegal &&
                       cond_ok(jmp_cond, carry_flag, stat_flag);
  assign jmp_target  = jmp_use_reg ? reg_target : imm_addr;
  assign fall_pc     = pc_add(pc_q, int'(step_len));
  assign push_val    = pc_add(pc_q, CALL_ADJ);

  always_comb begin
    pc_d = pc_q;
    if (fault_ev) pc_d = '0;
    else begin
      case (act)
        ACT_CLR:  pc_d = '0;
        ACT_CALL: pc_d = imm_addr;
        ACT_RET:  pc_d = pc_add(pop_val, RET_ADJ);
        ACT_JMP:  pc_d = jump_taken ? jmp_target : fall_pc;
        ACT_STEP: pc_d = fall_pc;
        default:  pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int SP_W   = 2,
  parameter int HALF_W = 5,
  parameter int NREG   = 16,
  parameter int LEN_W  = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              adv_req,
  input  logic [LEN_W-1:0]  step_len,
  input  logic              jmp_req,
  input  logic [2:0]        jmp_cond,
  input  logic              jmp_use_reg,
  input  logic [IDX_W-1:0]  jmp_reg_sel,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   imm_addr,
  input  logic              carry_flag,
  input  logic              stat_flag,
  input  logic              rf_we,
  input  logic [IDX_W:0]    rf_waddr,
  input  logic [HALF_W-1:0] rf_wdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              fault_rst
);
  // Internal events brought out by name for the checker.
  act_e             act;
  logic             push_ev, pop_ev, ovf_ev, unf_ev, jump_taken;
  logic [SP_W-1:0]  push_slot, pop_slot;
  logic [PC_W-1:0]  push_val, pop_val, reg_target;

  assign act = pick_act(clr_all, call_req, ret_req, jmp_req, adv_req);

  pcseq_sp_ctrl #(.SP_W(SP_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .act(act),
    .sp_q(sp), .push_slot(push_slot), .pop_slot(pop_slot),
    .push_ev(push_ev), .pop_ev(pop_ev), .ovf_ev(ovf_ev), .unf_ev(unf_ev),
    .fault_q(fault_rst)
  );

  pcseq_pair_rf #(.HALF_W(HALF_W), .NREG(NREG), .SP_W(SP_W)) u_rf (
    .clk(clk), .wr_en(rf_we), .wr_addr(rf_waddr), .wr_data(rf_wdata),
    .push_en(push_ev), .push_slot(push_slot), .push_val(push_val),
    .pop_slot(pop_slot), .pop_val(pop_val),
    .rd_sel(jmp_reg_sel), .rd_val(reg_target)
  );

  pcseq_pc_path #(.PC_W(PC_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .act(act), .fault_ev(ovf_ev || unf_ev),
    .step_len(step_len), .jmp_cond(jmp_cond), .jmp_use_reg(jmp_use_reg),
    .jmp_reg_sel(jmp_reg_sel), .imm_addr(imm_addr),
    .carry_flag(carry_flag), .stat_flag(stat_flag),
    .reg_target(reg_target), .pop_val(pop_val),
    .push_val(push_val), .jump_taken(jump_taken), .pc_q(pc)
  );
endmodule

// File: rtl/pc_stack_seq_chk.sv
module pc_stack_seq_chk #(
  parameter int PC_W  = 10,
  parameter int SP_W  = 2,
  parameter int LEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_all,
  input logic             adv_req,
  input logic             jmp_req,
  input logic             call_req,
  input logic             ret_req,
  input logic [LEN_W-1:0] step_len,
  input logic [PC_W-1:0]  imm_addr,
  input logic [PC_W-1:0]  pc,
  input logic [SP_W-1:0]  sp,
  input logic             fault_rst,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             ovf_ev,
  input logic             unf_ev
);
  // R1
  clr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (pc == '0) && (sp == '0) && !fault_rst);

  // R2
  step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_req && !clr_all && !call_req && !ret_req && !jmp_req)
      |=> pc == $past(pc) + PC_W'($past(step_len)));

  // R7
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (sp == $past(sp) + SP_W'(1)) && (pc == $past(imm_addr)));

  // R8
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> sp == $past(sp) - SP_W'(1));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (pc == '0) && (sp == '0) && fault_rst);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev |=> (pc == '0) && (sp == '0) && fault_rst);

  // R11
  call_over_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ret_req && !clr_all) |-> !pop_ev && !unf_ev);
endmodule

bind pc_stack_seq pc_stack_seq_chk #(.PC_W(PC_W), .SP_W(SP_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .adv_req(adv_req),
  .jmp_req(jmp_req), .call_req(call_req), .ret_req(ret_req),
  .step_len(step_len), .imm_addr(imm_addr), .pc(pc), .sp(sp),
  .fault_rst(fault_rst), .push_ev(push_ev), .pop_ev(pop_ev),
  .ovf_ev(ovf_ev), .unf_ev(unf_ev)
);

// File: tb/pc_stack_seq_tb.sv
module pc_stack_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_all = 0, adv_req = 0, jmp_req = 0, jmp_use_reg = 0;
  logic       call_req = 0, ret_req = 0, carry_flag = 0, stat_flag = 0, rf_we = 0;
  logic [1:0] step_len = 2'd1;
  logic [2:0] jmp_cond = 3'd0;
  logic [3:0] jmp_reg_sel = 4'd0;
  logic [9:0] imm_addr = 10'd0;
  logic [4:0] rf_waddr = 5'd0, rf_wdata = 5'd0;
  logic [9:0] pc;
  logic [1:0] sp;
  logic       fault_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pc_stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .adv_req(adv_req),
    .step_len(step_len), .jmp_req(jmp_req), .jmp_cond(jmp_cond),
    .jmp_use_reg(jmp_use_reg), .jmp_reg_sel(jmp_reg_sel),
    .call_req(call_req), .ret_req(ret_req), .imm_addr(imm_addr),
    .carry_flag(carry_flag), .stat_flag(stat_flag),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pc(pc), .sp(sp), .fault_rst(fault_rst)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    clr_all = 0; adv_req = 0; jmp_req = 0; call_req = 0; ret_req = 0;
    rf_we = 0; jmp_use_reg = 0; jmp_cond = 3'd0; step_len = 2'd1;
  endtask

  // One edge consumes the strobes; outputs read at the following falling edge.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic do_clr();
    clr_all = 1; cyc();
  endtask

  task automatic do_jmp_imm(input logic [9:0] a);
    jmp_req = 1; jmp_cond = 3'd0; imm_addr = a; cyc();
  endtask

  task automatic do_call(input logic [9:0] a);
    call_req = 1; imm_addr = a; cyc();
  endtask

  task automatic do_ret();
    ret_req = 1; cyc();
  endtask

  task automatic wr_pair(input logic [3:0] idx, input logic [9:0] v);
    rf_we = 1; rf_waddr = {1'b1, idx}; rf_wdata = v[9:5]; cyc();
    rf_we = 1; rf_waddr = {1'b0, idx}; rf_wdata = v[4:0]; cyc();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pc after reset", pc, 0);
    chk("R1 sp after reset", sp, 0);
    chk("R1 fault after reset", fault_rst, 0);
  endtask

  task automatic t_advance();
    adv_req = 1; step_len = 2'd1; cyc();
    chk("R2 step 1", pc, 1);
    adv_req = 1; step_len = 2'd3; cyc();
    chk("R2 step 3", pc, 4);
    adv_req = 1; step_len = 2'd2; cyc();
    chk("R2 step 2", pc, 6);
    cyc();
    chk("R2 hold with no strobe", pc, 6);
    do_jmp_imm(10'h3FF);
    adv_req = 1; step_len = 2'd2; cyc();
    chk("R2 wrap", pc, 10'h001);
  endtask

  task automatic t_jump_imm();
    do_jmp_imm(10'h155);
    chk("R3 immediate jump", pc, 10'h155);
  endtask

  task automatic t_cond();
    carry_flag = 1; stat_flag = 0;
    jmp_req = 1; jmp_cond = 3'd1; imm_addr = 10'h020; cyc();
    chk("R4 carry taken", pc, 10'h020);
    jmp_req = 1; jmp_cond = 3'd2; imm_addr = 10'h040; cyc();
    chk("R4 no-carry skipped", pc, 10'h021);
    jmp_req = 1; jmp_cond = 3'd3; imm_addr = 10'h040; cyc();
    chk("R4 flag skipped", pc, 10'h022);
    jmp_req = 1; jmp_cond = 3'd4; imm_addr = 10'h080; cyc();
    chk("R4 no-flag taken", pc, 10'h080);
    jmp_req = 1; jmp_cond = 3'd5; imm_addr = 10'h300; step_len = 2'd3; cyc();
    chk("R4 code 5 never taken", pc, 10'h083);
    carry_flag = 0; stat_flag = 0;
  endtask

  task automatic t_reg_jump();
    wr_pair(4'h1, 10'h345);
    jmp_req = 1; jmp_use_reg = 1; jmp_reg_sel = 4'h1; cyc();
    chk("R5 pair 1 target", pc, 10'h345);
    carry_flag = 0;
    jmp_req = 1; jmp_use_reg = 1; jmp_reg_sel = 4'h1; jmp_cond = 3'd1; cyc();
    chk("R5 pair jump, carry clear", pc, 10'h346);
  endtask

  task automatic t_reg0();
    wr_pair(4'h0, 10'h111);
    jmp_req = 1; jmp_use_reg = 1; jmp_reg_sel = 4'h0; step_len = 2'd1; cyc();
    chk("R6 pair 0 ignored", pc, 10'h347);
  endtask

  task automatic t_call_ret();
    do_clr();
    do_jmp_imm(10'h100);
    do_call(10'h200);
    chk("R7 call pc", pc, 10'h200);
    chk("R7 call sp", sp, 1);
    do_call(10'h300);
    chk("R7 nested call pc", pc, 10'h300);
    chk("R7 nested call sp", sp, 2);
    do_ret();
    chk("R8 return pc", pc, 10'h203);
    chk("R8 return sp", sp, 1);
    do_ret();
    chk("R8 outer return pc", pc, 10'h103);
    chk("R8 outer return sp", sp, 0);
  endtask

  task automatic t_overflow();
    do_clr();
    wr_pair(4'hC, 10'h2AA);
    do_call(10'h010);
    do_call(10'h020);
    do_call(10'h030);
    chk("R9 three calls sp", sp, 3);
    do_call(10'h040);
    chk("R9 overflow pc", pc, 0);
    chk("R9 overflow sp", sp, 0);
    chk("R9 overflow fault", fault_rst, 1);
    cyc();
    chk("R9 fault is one cycle", fault_rst, 0);
    jmp_req = 1; jmp_use_reg = 1; jmp_reg_sel = 4'hC; cyc();
    chk("R9 slot 3 untouched", pc, 10'h2AA);
  endtask

  task automatic t_underflow();
    do_clr();
    do_jmp_imm(10'h077);
    do_ret();
    chk("R10 underflow pc", pc, 0);
    chk("R10 underflow sp", sp, 0);
    chk("R10 underflow fault", fault_rst, 1);
    cyc();
    chk("R10 fault cleared", fault_rst, 0);
  endtask

  task automatic t_priority();
    do_clr();
    do_jmp_imm(10'h050);
    call_req = 1; ret_req = 1; jmp_req = 1; adv_req = 1; imm_addr = 10'h060; cyc();
    chk("R11 call wins pc", pc, 10'h060);
    chk("R11 call wins sp", sp, 1);
    ret_req = 1; jmp_req = 1; adv_req = 1; imm_addr = 10'h3C0; cyc();
    chk("R11 return wins pc", pc, 10'h053);
    chk("R11 return wins sp", sp, 0);
    jmp_req = 1; adv_req = 1; imm_addr = 10'h070; cyc();
    chk("R11 jump over step", pc, 10'h070);
    clr_all = 1; call_req = 1; imm_addr = 10'h123; cyc();
    chk("R11 clear wins pc", pc, 0);
    chk("R11 clear wins sp", sp, 0);
  endtask

  task automatic t_shared();
    do_clr();
    do_jmp_imm(10'h0A0);
    do_call(10'h1C0);
    jmp_req = 1; jmp_use_reg = 1; jmp_reg_sel = 4'hF; cyc();
    chk("R12 saved address via pair F", pc, 10'h0A1);
    wr_pair(4'hF, 10'h3F0);
    do_ret();
    chk("R12 return uses rewritten slot", pc, 10'h3F2);
    chk("R12 sp after return", sp, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_advance();
    t_jump_imm();
    t_cond();
    t_reg_jump();
    t_reg0();
    t_call_ret();
    t_overflow();
    t_underflow();
    t_priority();
    t_shared();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule